// File: doc/BRIEF.md
# Programmable Pulse Pattern Sequencer

This block is the execution core of a 32-channel digital pattern generator. It runs a short program held in an external instruction memory. Each 128-bit instruction says which channels go high and which go low, and how long that state holds. It also names a control action that picks the next slot: stop, step, open or close a counted loop, call or return from a subroutine, or jump. Counted loops and subroutine return addresses share one hardware stack, so loops and calls can nest freely up to its depth.

The core drives the memory's address. The memory must return the addressed word in the same cycle, as an asynchronous read. A one-cycle `start` pulse while the core is idle begins execution at slot 0. The `running` output falls once a stop instruction or a fault ends the run. The stack pointer, the live dwell counter and three sticky fault flags are visible as status.

Top module: `pulse_seq`

## Requirements
- R1: After reset, `chan` is all zero, `running` is 0, `imem_addr` is 0, `sp` is 0 and the three fault flags are 0.
- R2: A `start` pulse while idle begins execution at slot 0 with an empty stack and clears all fault flags. A `start` pulse while running has no effect on the run.
- R3: Word fields are SET mask in bits 31:0, CLEAR mask in bits 63:32, delay in bits 95:64, payload in bits 115:96 and opcode in bits 118:116. Bit i of a mask controls `chan[i]`. A SET bit drives the channel high and a CLEAR bit drives it low. A channel named in neither mask keeps its level, and a channel named in both goes high.
- R4: Every instruction, whatever its opcode, occupies exactly 3 + delay cycles. The new channel levels appear from its second cycle and last for 3 + delay cycles.
- R5: Opcode 0 (stop) applies its masks, leaves `imem_addr` on its own slot and drops `running`. While idle, the channels and the address do not change.
- R6: Opcode 1 moves to the next slot. Opcode 6 jumps to the low address bits of the payload without touching the stack. Opcode 7 acts as opcode 1.
- R7: Opcode 2 pushes a loop entry holding the next slot and a repeat count N taken from the payload. Opcode 3 jumps back to that slot while the count is above 1, and otherwise pops the entry and falls through. The body therefore runs N times, and N = 0 runs it once.
- R8: Opcode 4 pushes the next slot and jumps to the payload address. Opcode 5 pops the entry and jumps to the address it holds. Loop and call entries share one stack, and `sp` moves by at most one per instruction.
- R9: A push when the stack holds DEPTH (256) entries sets `ovf` and stops the run, with `sp` left at DEPTH.
- R10: Opcode 3 or 5 on an empty stack sets `unf` and stops the run.
- R11: Opcode 3 that finds a call entry on top, or opcode 5 that finds a loop entry on top, sets `tagerr` and stops the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run from slot 0 when idle |
| imem_addr | output | AW (12) | Instruction address, which is also the program counter |
| imem_data | input | 128 | Instruction word for `imem_addr`, returned in the same cycle |
| chan | output | 32 | Channel levels |
| running | output | 1 | High while a program executes |
| sp | output | $clog2(DEPTH)+1 (9) | Stack entry count |
| dly | output | 32 | Remaining dwell cycles of the current instruction |
| ovf | output | 1 | Stack overflow fault, sticky until the next start |
| unf | output | 1 | Stack underflow fault, sticky until the next start |
| tagerr | output | 1 | Wrong stack entry type fault, sticky until the next start |

## Verification
A wrong program counter or stack entry shows up at the ports only through the total run length and the number of pulses on a channel. The bench therefore counts running cycles and rising edges for whole programs. A single miscounted loop or a misplaced return changes both totals within one iteration. A dwell off by one cycle changes the measured high time of a pulse at once. Stack faults must raise their flag and drop `running` in the cycle after the offending instruction's last cycle. Stop instructions are checked by reading `imem_addr` and the channels once the run has ended.

// File: rtl/pulse_seq.sv
module pulse_seq #(
  parameter int AW    = 12,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic [AW-1:0]              imem_addr,
  input  logic [127:0]               imem_data,
  output logic [31:0]                chan,
  output logic                       running,
  output logic [$clog2(DEPTH):0]     sp,
  output logic [31:0]                dly,
  output logic                       ovf,
  output logic                       unf,
  output logic                       tagerr
);
  localparam int SPW  = $clog2(DEPTH) + 1;
  localparam int IXW  = SPW - 1;
  localparam int PAYW = 20;

  typedef enum logic [2:0] {S_IDLE, S_P0, S_P1, S_P2, S_DLY} st_t;
  typedef enum logic [2:0] {OP_STOP, OP_NEXT, OP_LOOP, OP_ENDL, OP_CALL, OP_RET, OP_JUMP, OP_SPARE} op_t;

  st_t             st;
  logic [AW-1:0]   pc;
  logic [2:0]      op;
  logic [PAYW-1:0] pay;
  logic [SPW-1:0]  sp_q;

  logic            stk_loop [DEPTH];
  logic [AW-1:0]   stk_adr  [DEPTH];
  logic [PAYW-1:0] stk_cnt  [DEPTH];

  logic            last, full, empty;
  logic [IXW-1:0]  top_i, push_i;
  logic [AW-1:0]   pc_inc, nxt_pc;
  logic            push, push_loop, pop, dec, stop, e_ovf, e_unf, e_tag;

  assign imem_addr = pc;
  assign running   = (st != S_IDLE);
  assign sp        = sp_q;
  assign last      = (st == S_P2 && dly == 32'd0) || (st == S_DLY && dly == 32'd1);
  assign full      = (sp_q == SPW'(DEPTH));
  assign empty     = (sp_q == '0);
  assign push_i    = sp_q[IXW-1:0];
  assign top_i     = sp_q[IXW-1:0] - IXW'(1);
  assign pc_inc    = pc + AW'(1);

  always_comb begin
    nxt_pc = pc_inc;
    push = 1'b0; push_loop = 1'b0; pop = 1'b0; dec = 1'b0;
    stop = 1'b0; e_ovf = 1'b0; e_unf = 1'b0; e_tag = 1'b0;
    case (op_t'(op))
      OP_STOP: stop = 1'b1;
      OP_LOOP: if (full) e_ovf = 1'b1; else begin push = 1'b1; push_loop = 1'b1; end
      OP_ENDL:
        if (empty) e_unf = 1'b1;
        else if (!stk_loop[top_i]) e_tag = 1'b1;
        else if (stk_cnt[top_i] > PAYW'(1)) begin dec = 1'b1; nxt_pc = stk_adr[top_i]; end
        else pop = 1'b1;
      OP_CALL: if (full) e_ovf = 1'b1; else begin push = 1'b1; nxt_pc = pay[AW-1:0]; end
      OP_RET:
        if (empty) e_unf = 1'b1;
        else if (stk_loop[top_i]) e_tag = 1'b1;
        else begin pop = 1'b1; nxt_pc = stk_adr[top_i]; end
      OP_JUMP: nxt_pc = pay[AW-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; op <= '0; pay <= '0; sp_q <= '0;
      chan <= '0; dly <= '0; ovf <= 1'b0; unf <= 1'b0; tagerr <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_P0; pc <= '0; sp_q <= '0;
          ovf <= 1'b0; unf <= 1'b0; tagerr <= 1'b0;
        end
        S_P0: begin
          chan <= (chan & ~imem_data[63:32]) | imem_data[31:0];
          dly  <= imem_data[95:64];
          pay  <= imem_data[115:96];
          op   <= imem_data[118:116];
          st   <= S_P1;
        end
        S_P1: st <= S_P2;
        S_P2: if (dly != 32'd0) st <= S_DLY;
        S_DLY: dly <= dly - 32'd1;
        default: st <= S_IDLE;
      endcase
      if (last) begin
        if (stop || e_ovf || e_unf || e_tag) begin
          st <= S_IDLE;
          ovf <= e_ovf; unf <= e_unf; tagerr <= e_tag;
        end else begin
          st <= S_P0;
          pc <= nxt_pc;
          if (push) sp_q <= sp_q + SPW'(1);
          else if (pop) sp_q <= sp_q - SPW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (last && push) begin
      stk_loop[push_i] <= push_loop;
      stk_adr[push_i]  <= pc_inc;
      stk_cnt[push_i]  <= push_loop ? pay : '0;
    end else if (last && dec) begin
      stk_cnt[top_i] <= stk_cnt[top_i] - PAYW'(1);
    end
  end
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk #(
  parameter int AW    = 12,
  parameter int DEPTH = 256
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [AW-1:0]          imem_addr,
  input logic [31:0]            chan,
  input logic                   running,
  input logic [$clog2(DEPTH):0] sp,
  input logic                   ovf,
  input logic                   unf,
  input logic                   tagerr
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !running && sp == '0 && chan == '0); // R1
  AST_START_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> imem_addr == '0 && sp == '0 && !ovf && !unf && !tagerr); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start |=> !running && $stable(chan) && $stable(imem_addr)); // R5
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> sp == $past(sp) || sp == $past(sp) + 1'b1 || sp == $past(sp) - 1'b1); // R8
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sp <= DEPTH); // R9
  AST_OVF_HALT: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> !running); // R9
  AST_UNF_HALT: assert property (@(posedge clk) disable iff (!rst_n) unf |-> !running); // R10
  AST_TAG_HALT: assert property (@(posedge clk) disable iff (!rst_n) tagerr |-> !running); // R11
endmodule

bind pulse_seq pulse_seq_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .imem_addr(imem_addr), .chan(chan),
  .running(running), .sp(sp), .ovf(ovf), .unf(unf), .tagerr(tagerr)
);

// File: tb/pulse_seq_tb_top.sv
module pulse_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [11:0]  imem_addr;
  logic [127:0] imem_data;
  logic [31:0]  chan, dly;
  logic         running, ovf, unf, tagerr;
  logic [8:0]   sp;
  logic [127:0] mem [0:63];
  int nchk = 0, nbad = 0, cyc = 0, rises = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign imem_data = mem[imem_addr[5:0]];

  pulse_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .imem_addr(imem_addr),
    .imem_data(imem_data), .chan(chan), .running(running), .sp(sp), .dly(dly),
    .ovf(ovf), .unf(unf), .tagerr(tagerr));

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic eq(input string what, input longint act, input longint exp);
    chk(act == exp, what, act, exp);
  endtask

  task automatic put(input int s, input logic [31:0] set, input logic [31:0] clr,
                     input logic [31:0] d, input logic [2:0] op, input logic [19:0] pay);
    mem[s] = {9'h0, op, pay, d, clr, set};
  endtask

  task automatic wipe();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic run(input int mon, input bit restart);
    logic prev;
    prev = chan[mon];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0; rises = 0;
    while (running && cyc < 5000) begin
      cyc++;
      if (chan[mon] && !prev) rises++;
      prev = chan[mon];
      start = (restart && cyc == 4);
      @(negedge clk);
    end
    start = 1'b0;
    if (chan[mon] && !prev) rises++;
    chk(cyc < 5000, "run ended", cyc, 0);
  endtask

  task automatic t_reset();
    eq("R1 chan", chan, 0);
    eq("R1 running", running, 0);
    eq("R1 addr", imem_addr, 0);
    eq("R1 sp", sp, 0);
    eq("R1 flags", {ovf, unf, tagerr}, 0);
  endtask

  task automatic t_masks();
    wipe();
    put(0, 32'hF0F0_0000, 32'h0, 0, 3'd1, 0);
    put(1, 32'h0000_0001, 32'hF000_0000, 0, 3'd1, 0);
    put(2, 32'h0000_0003, 32'h0000_0003, 0, 3'd0, 0);
    run(0, 0);
    eq("R3 final channels", chan, 32'h00F0_0003);
    eq("R4 three instr cycles", cyc, 9);
    eq("R5 addr stays on stop slot", imem_addr, 2);
    eq("R5 running low", running, 0);
    repeat (5) @(negedge clk);
    eq("R5 idle hold", chan, 32'h00F0_0003);
  endtask

  task automatic t_dwell();
    int hi;
    wipe();
    put(0, 32'h100, ~32'h100, 5, 3'd1, 0);
    put(1, 32'h0, 32'hFFFF_FFFF, 2, 3'd0, 0);
    hi = 0;
    fork
      run(8, 1);
      while (running || hi == 0) begin @(negedge clk); if (chan[8]) hi++; end
    join
    eq("R4 pulse width", hi, 8);
    eq("R2 R4 run length with restart", cyc, 13);
    eq("R3 cleared", chan, 0);
  endtask

  task automatic t_jump();
    wipe();
    put(0, 32'h1, 32'h0, 0, 3'd6, 20'd10);
    put(1, 32'h2, 32'h0, 0, 3'd0, 0);
    put(10, 32'h4, 32'h0, 1, 3'd7, 0);
    put(11, 32'h0, 32'h0, 0, 3'd0, 0);
    run(0, 0);
    eq("R6 jump skips slot 1", chan, 32'h5);
    eq("R6 addr", imem_addr, 11);
    eq("R6 cycles", cyc, 10);
  endtask

  task automatic t_loop(input int n, input int body);
    wipe();
    put(0, 32'h0, 32'hFFFF_FFFF, 0, 3'd2, 20'(n));
    put(1, 32'h1, 32'h0, 2, 3'd1, 0);
    put(2, 32'h0, 32'h1, 0, 3'd3, 0);
    put(3, 32'h0, 32'h0, 0, 3'd0, 0);
    run(0, 0);
    eq("R7 body count", rises, body);
    eq("R7 loop cycles", cyc, 6 + 8 * body);
    eq("R7 stack empty", sp, 0);
  endtask

  task automatic t_nest();
    wipe();
    put(0, 32'h0, 32'hFFFF_FFFF, 0, 3'd2, 20'd2);
    put(1, 32'h0, 32'h0, 0, 3'd4, 20'd20);
    put(2, 32'h0, 32'h0, 0, 3'd3, 0);
    put(3, 32'h0, 32'h0, 0, 3'd0, 0);
    put(20, 32'h2, 32'h0, 0, 3'd1, 0);
    put(21, 32'h0, 32'h2, 0, 3'd5, 0);
    run(1, 0);
    eq("R8 calls in loop", rises, 2);
    eq("R8 cycles", cyc, 30);
    eq("R8 sp back to zero", sp, 0);
    eq("R8 no fault", {ovf, unf, tagerr}, 0);
  endtask

  task automatic t_ovf();
    wipe();
    put(0, 32'h0, 32'h0, 0, 3'd4, 20'd0);
    run(0, 0);
    eq("R9 ovf flag", ovf, 1);
    eq("R9 sp full", sp, 256);
    eq("R9 cycles", cyc, 771);
  endtask

  task automatic t_unf();
    wipe();
    put(0, 32'h0, 32'h0, 0, 3'd5, 0);
    run(0, 0);
    eq("R10 unf flag", unf, 1);
    eq("R2 ovf cleared by start", ovf, 0);
    eq("R10 cycles", cyc, 3);
    put(0, 32'h0, 32'h0, 0, 3'd3, 0);
    run(0, 0);
    eq("R10 unf on loop end", unf, 1);
  endtask

  task automatic t_tag();
    wipe();
    put(0, 32'h0, 32'h0, 0, 3'd4, 20'd5);
    put(5, 32'h0, 32'h0, 0, 3'd3, 0);
    run(0, 0);
    eq("R11 loop end on call entry", tagerr, 1);
    eq("R11 cycles", cyc, 6);
    wipe();
    put(0, 32'h0, 32'h0, 0, 3'd2, 20'd2);
    put(1, 32'h0, 32'h0, 0, 3'd5, 0);
    run(0, 0);
    eq("R11 return on loop entry", tagerr, 1);
    eq("R11 sp kept", sp, 1);
  endtask

  initial begin
    wipe();
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_masks();
    t_dwell();
    t_jump();
    t_loop(3, 3);
    t_loop(0, 1);
    t_nest();
    t_ovf();
    t_unf();
    t_tag();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule